// File: doc/BRIEF.md
# Indexed Colour Palette with Indirect Register Port

The block is a 256-entry colour lookup table for an indexed-colour display path. A host programs it through a write-only register port with three targets: a pointer register, a colour data port and a control port. All three take their byte from the top lane of a 32-bit bus word (bits 31:24). Writing the pointer selects a table entry. Three colour writes then deliver red, green and blue in that order. The completed 24-bit colour is committed to the selected entry, and the pointer moves on to the next entry. This lets a whole palette load as one stream after a single pointer write.

The same pointer also selects one of four indirect control registers, which the control port writes:

| Index | Register | Value after reset |
|---|---|---|
| 4 | read mask | 0xFF |
| 5 | blink mask | 0x00 |
| 6 | overlay/command control | 0x73 |
| 7 | test register | 0x00 |

On the pixel side, each clock presents an 8-bit index. The index is ANDed with the read mask, and the stored colour comes back one cycle later.

A small state machine sequences the colour components. Its states are COMP_RED, COMP_GREEN and COMP_BLUE, and it has these transitions:

- **Red to green:** a colour write in COMP_RED stores the byte as red and moves to COMP_GREEN.
- **Green to blue:** a colour write in COMP_GREEN stores the byte as green and moves to COMP_BLUE.
- **Blue to red (commit):** a colour write in COMP_BLUE commits {red, green, byte}, increments the pointer and returns to COMP_RED.
- **Pointer reload:** a pointer write from any state loads the pointer and forces COMP_RED.
- **Hold:** a control write, a write to the unused port code, or no write leaves the state and the pointer as they are.

Top module: `palette_lut`

## Requirements
- R1: A write with `host_sel`=0 loads the pointer from bits 31:24 of `host_wdata` and puts the component sequencer in COMP_RED. Bits 23:0 are ignored.
- R2: With `host_sel`=1, successive writes supply red, then green, then blue, each from bits 31:24. Only the blue write updates the table. The entry becomes {red[23:16], green[15:8], blue[7:0]}, and the red and green writes leave the pointer unchanged.
- R3: After a blue write the pointer increments by one, wrapping from 255 to 0, and the sequencer returns to COMP_RED. The next three colour writes therefore fill the following entry.
- R4: A pointer write between colour writes discards the staged red and green. The entry it interrupted keeps its old value, and the sequence restarts at red.
- R5: A write with `host_sel`=2 stores bits 31:24 into the indirect register whose index equals the pointer. Indices 4 (read mask), 5 (blink mask), 6 (overlay control) and 7 (test) exist, and any other index is ignored. A control write changes neither the pointer nor the sequencer.
- R6: After reset, the read mask is 0xFF, the blink mask 0x00, the overlay control 0x73 and the test register 0x00. Every table entry reads 0, `pix_color` is 0, the pointer is 0 and the sequencer is in COMP_RED.
- R7: `pix_color` shows the table entry at (`pix_index` AND read mask), sampled at one clock edge and visible after that edge. A read-mask write at the same edge takes effect from the next edge.
- R8: A lookup of the entry that a blue write commits at the same edge returns the old colour. The new colour appears from the following lookup.
- R9: A write with `host_sel`=3, or any cycle with `host_we` low, changes no table entry, control register, pointer or sequencer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Write target: 0 pointer, 1 colour data, 2 control, 3 unused |
| host_wdata | input | 32 | Host write word; only bits 31:24 are used |
| pix_index | input | 8 | Pixel colour index |
| pix_color | output | 24 | Looked-up colour {R,G,B}, one cycle after the index |
| blink_mask | output | 8 | Indirect register 5 |
| overlay_ctl | output | 8 | Indirect register 6 |
| test_reg | output | 8 | Indirect register 7 |

## Verification
A host commit from a blue write and a pixel lookup can land on the same table entry at the same clock edge. The second colliding pair is a read-mask write and a lookup at the same edge. Directed steps set the pointer to an entry and present that entry's index on `pix_index` during the blue write. The expected output is the old colour in that cycle and the new colour in the next. A mask write is likewise paired with a lookup whose masked and unmasked indices differ. Random steps mix all four port codes with random indices, and the bench model reproduces both orderings independently.

// File: rtl/palette_lut_pkg.sv
package palette_lut_pkg;

    typedef enum logic [1:0] {
        COMP_RED   = 2'd0,
        COMP_GREEN = 2'd1,
        COMP_BLUE  = 2'd2
    } comp_e;

    typedef enum logic [1:0] {
        PORT_PTR   = 2'd0,
        PORT_COLOR = 2'd1,
        PORT_CTRL  = 2'd2,
        PORT_NONE  = 2'd3
    } port_e;

endpackage

// File: rtl/palette_lut_seq.sv
module palette_lut_seq
    import palette_lut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ptr_wr,
    input  logic                color_wr,
    input  logic [COMP_W-1:0]   wbyte,
    output logic [IDX_W-1:0]    ptr_q,
    output comp_e               state_q,
    output logic                commit,
    output logic [3*COMP_W-1:0] commit_data
);

    comp_e               state_d;
    logic [IDX_W-1:0]    ptr_d;
    logic [COMP_W-1:0]   red_q, red_d;
    logic [COMP_W-1:0]   green_q, green_d;

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        red_d   = red_q;
        green_d = green_q;
        if (ptr_wr) begin
            ptr_d   = wbyte[IDX_W-1:0];
            state_d = COMP_RED;
        end else if (color_wr) begin
            unique case (state_q)
                COMP_RED: begin
                    red_d   = wbyte;
                    state_d = COMP_GREEN;
                end
                COMP_GREEN: begin
                    green_d = wbyte;
                    state_d = COMP_BLUE;
                end
                COMP_BLUE: begin
                    ptr_d   = ptr_q + 1'b1;
                    state_d = COMP_RED;
                end
                default: state_d = COMP_RED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= COMP_RED;
            ptr_q   <= '0;
            red_q   <= '0;
            green_q <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            red_q   <= red_d;
            green_q <= green_d;
        end
    end

    always_comb begin
        commit      = color_wr && !ptr_wr && (state_q == COMP_BLUE);
        commit_data = {red_q, green_q, wbyte};
    end

endmodule

// File: rtl/palette_lut_ctrl.sv
module palette_lut_ctrl #(
    parameter int                     IDX_W    = 8,
    parameter int                     COMP_W   = 8,
    parameter int                     NREG     = 4,
    parameter int                     BASE     = 4,
    parameter logic [NREG*COMP_W-1:0] RST_VALS = {8'h00, 8'h73, 8'h00, 8'hFF}
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [IDX_W-1:0]            sel_idx,
    input  logic [COMP_W-1:0]           wbyte,
    output logic [NREG-1:0][COMP_W-1:0] regs_q
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(BASE + g);
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= RST_VALS[g*COMP_W +: COMP_W];
            else if (wr && (sel_idx == MY_IDX))
                regs_q[g] <= wbyte;
        end
    end

endmodule

// File: rtl/palette_lut_mem.sv
module palette_lut_mem #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] table_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) table_q[i] <= '0;
        end else if (wr) begin
            table_q[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= table_q[raddr];
    end

endmodule

// File: rtl/palette_lut.sv
module palette_lut
    import palette_lut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    parameter int BUS_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic [1:0]          host_sel,
    input  logic [BUS_W-1:0]    host_wdata,
    input  logic [IDX_W-1:0]    pix_index,
    output logic [3*COMP_W-1:0] pix_color,
    output logic [COMP_W-1:0]   blink_mask,
    output logic [COMP_W-1:0]   overlay_ctl,
    output logic [COMP_W-1:0]   test_reg
);

    localparam int LANE_LSB = BUS_W - COMP_W;
    localparam int NREG     = 4;

    port_e                         port;
    logic [COMP_W-1:0]             wbyte;
    logic                          ptr_wr, color_wr, ctrl_wr;
    logic [IDX_W-1:0]              ptr_q;
    comp_e                         seq_state;
    logic                          commit;
    logic [3*COMP_W-1:0]           commit_data;
    logic [NREG-1:0][COMP_W-1:0]   ctrl_q;
    logic [IDX_W-1:0]              masked_idx;
    logic                          unused_low;

    assign port       = port_e'(host_sel);
    assign wbyte      = host_wdata[BUS_W-1:LANE_LSB];
    assign unused_low = ^host_wdata[LANE_LSB-1:0];

    always_comb begin
        ptr_wr   = 1'b0;
        color_wr = 1'b0;
        ctrl_wr  = 1'b0;
        if (host_we) begin
            unique case (port)
                PORT_PTR:   ptr_wr   = 1'b1;
                PORT_COLOR: color_wr = 1'b1;
                PORT_CTRL:  ctrl_wr  = 1'b1;
                default:    ;
            endcase
        end
    end

    palette_lut_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ptr_wr      (ptr_wr),
        .color_wr    (color_wr),
        .wbyte       (wbyte),
        .ptr_q       (ptr_q),
        .state_q     (seq_state),
        .commit      (commit),
        .commit_data (commit_data)
    );

    palette_lut_ctrl #(.IDX_W(IDX_W), .COMP_W(COMP_W), .NREG(NREG), .BASE(4)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ctrl_wr),
        .sel_idx (ptr_q),
        .wbyte   (wbyte),
        .regs_q  (ctrl_q)
    );

    assign masked_idx  = pix_index & ctrl_q[0][IDX_W-1:0];
    assign blink_mask  = ctrl_q[1];
    assign overlay_ctl = ctrl_q[2];
    assign test_reg    = ctrl_q[3];

    palette_lut_mem #(.IDX_W(IDX_W), .DATA_W(3*COMP_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (commit),
        .waddr (ptr_q),
        .wdata (commit_data),
        .raddr (masked_idx),
        .rdata (pix_color)
    );

endmodule

// File: rtl/palette_lut_chk.sv
module palette_lut_chk
    import palette_lut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_we,
    input logic [1:0]       host_sel,
    input logic [BUS_W-1:0] host_wdata,
    input logic [IDX_W-1:0] ptr,
    input comp_e            comp
);

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_sel == 2'd0) |=> (ptr == $past(host_wdata[BUS_W-1 -: IDX_W]) && comp == COMP_RED)); // R1

    AST_RED_TO_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_sel == 2'd1 && comp == COMP_RED) |=> (comp == COMP_GREEN && $stable(ptr))); // R2

    AST_GREEN_TO_BLUE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_sel == 2'd1 && comp == COMP_GREEN) |=> (comp == COMP_BLUE && $stable(ptr))); // R2

    AST_BLUE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_sel == 2'd1 && comp == COMP_BLUE) |=> (comp == COMP_RED && ptr == IDX_W'($past(ptr) + 1'b1))); // R3

    AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_sel == 2'd2) |=> ($stable(ptr) && $stable(comp))); // R5

    AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_we || host_sel == 2'd3) |=> ($stable(ptr) && $stable(comp))); // R9

endmodule

bind palette_lut palette_lut_chk #(.IDX_W(IDX_W), .BUS_W(BUS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .ptr        (ptr_q),
    .comp       (seq_state)
);

// File: tb/palette_lut_bench.sv
module palette_lut_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_we;
    logic [1:0]  host_sel;
    logic [31:0] host_wdata;
    logic [7:0]  pix_index;
    logic [23:0] pix_color;
    logic [7:0]  blink_mask, overlay_ctl, test_reg;

    always #4 clk = ~clk;

    palette_lut u_palette_lut (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_we     (host_we),
        .host_sel    (host_sel),
        .host_wdata  (host_wdata),
        .pix_index   (pix_index),
        .pix_color   (pix_color),
        .blink_mask  (blink_mask),
        .overlay_ctl (overlay_ctl),
        .test_reg    (test_reg)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [23:0] m_mem [256];
    logic [7:0]  m_mask, m_blink, m_ovl, m_test, m_ptr, m_r, m_g;
    int          m_comp;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] lookup(input logic [7:0] idx);
        return m_mem[idx & m_mask];
    endfunction

    task automatic model_write(input logic we, input logic [1:0] sel, input logic [31:0] d);
        logic [7:0] b;
        b = d[31:24];
        if (!we) return;
        case (sel)
            2'd0: begin m_ptr = b; m_comp = 0; end
            2'd1: begin
                if (m_comp == 0) begin m_r = b; m_comp = 1; end
                else if (m_comp == 1) begin m_g = b; m_comp = 2; end
                else begin m_mem[m_ptr] = {m_r, m_g, b}; m_ptr = m_ptr + 8'd1; m_comp = 0; end
            end
            2'd2: begin
                case (m_ptr)
                    8'd4: m_mask  = b;
                    8'd5: m_blink = b;
                    8'd6: m_ovl   = b;
                    8'd7: m_test  = b;
                    default: ;
                endcase
            end
            default: ;
        endcase
    endtask

    task automatic step(input logic we, input logic [1:0] sel, input logic [31:0] d,
                        input logic [7:0] idx, input string tag);
        logic [23:0] exp;
        host_we = we; host_sel = sel; host_wdata = d; pix_index = idx;
        @(posedge clk);
        exp = lookup(idx);
        model_write(we, sel, d);
        @(negedge clk);
        chk(tag, {8'h0, pix_color}, {8'h0, exp});
        chk({tag, " R5 ctrl"}, {8'h0, blink_mask, overlay_ctl, test_reg}, {8'h0, m_blink, m_ovl, m_test});
    endtask

    task automatic wr_ptr(input logic [7:0] p, input string tag);
        step(1'b1, 2'd0, {p, 24'hA5A5A5}, 8'h00, tag);
    endtask
    task automatic wr_col(input logic [7:0] c, input logic [7:0] idx, input string tag);
        step(1'b1, 2'd1, {c, 24'h5A5A5A}, idx, tag);
    endtask
    task automatic wr_ctl(input logic [7:0] c, input string tag);
        step(1'b1, 2'd2, {c, 24'h0F0F0F}, 8'h00, tag);
    endtask
    task automatic look(input logic [7:0] idx, input string tag);
        step(1'b0, 2'd0, 32'h0, idx, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) m_mem[i] = 24'h0;
        m_mask = 8'hFF; m_blink = 8'h00; m_ovl = 8'h73; m_test = 8'h00;
        m_ptr = 8'h00; m_r = 8'h00; m_g = 8'h00; m_comp = 0;
        rst_n = 1'b0; host_we = 1'b0; host_sel = 2'd0; host_wdata = '0; pix_index = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: reset state
        chk("R6 pix_color", {8'h0, pix_color}, 32'h0);
        chk("R6 blink", {24'h0, blink_mask}, 32'h00);
        chk("R6 overlay", {24'h0, overlay_ctl}, 32'h73);
        chk("R6 test", {24'h0, test_reg}, 32'h00);
        look(8'hAB, "R6 lookup");
        // R6: pointer starts at 0 in red phase
        wr_col(8'h11, 8'h00, "R6"); wr_col(8'h22, 8'h00, "R6"); wr_col(8'h33, 8'h00, "R6");
        look(8'h00, "R6 entry0");
        chk("R6 entry0 value", {8'h0, pix_color}, 32'h112233);

        // R1 and R2: pointer from top byte, components in order
        wr_ptr(8'h05, "R1");
        wr_col(8'hC1, 8'h05, "R2"); wr_col(8'hC2, 8'h05, "R2");
        look(8'h05, "R2 partial no update");
        chk("R2 unchanged before blue", {8'h0, pix_color}, 32'h0);
        wr_col(8'hC3, 8'h05, "R2");
        look(8'h05, "R2");
        chk("R2 entry5", {8'h0, pix_color}, 32'hC1C2C3);
        // R3: next entry after auto-increment
        wr_col(8'hD1, 8'h06, "R3"); wr_col(8'hD2, 8'h06, "R3"); wr_col(8'hD3, 8'h06, "R3");
        look(8'h06, "R3");
        chk("R3 entry6", {8'h0, pix_color}, 32'hD1D2D3);
        // R3: wrap 255 -> 0
        wr_ptr(8'hFF, "R3");
        wr_col(8'hE1, 8'h00, "R3"); wr_col(8'hE2, 8'h00, "R3"); wr_col(8'hE3, 8'h00, "R3");
        wr_col(8'hF1, 8'h00, "R3"); wr_col(8'hF2, 8'h00, "R3"); wr_col(8'hF3, 8'h00, "R3");
        look(8'h00, "R3 wrap");
        chk("R3 wrap entry0", {8'h0, pix_color}, 32'hF1F2F3);

        // R4: pointer write mid-sequence
        wr_ptr(8'h10, "R4"); wr_col(8'h77, 8'h10, "R4"); wr_col(8'h88, 8'h10, "R4");
        wr_ptr(8'h10, "R4");
        wr_col(8'h01, 8'h10, "R4"); wr_col(8'h02, 8'h10, "R4"); wr_col(8'h03, 8'h10, "R4");
        look(8'h10, "R4");
        chk("R4 entry10", {8'h0, pix_color}, 32'h010203);

        // R5 / R7: read mask and other indirect registers
        wr_ptr(8'h04, "R5"); wr_ctl(8'h0F, "R5");
        look(8'h35, "R7 masked");
        chk("R7 mask 0x0F on 0x35", {8'h0, pix_color}, 32'hC1C2C3);
        wr_ctl(8'hFF, "R5");
        wr_ptr(8'h05, "R5"); wr_ctl(8'h5B, "R5");
        wr_ptr(8'h06, "R5"); wr_ctl(8'h00, "R5");
        wr_ptr(8'h07, "R5"); wr_ctl(8'hE7, "R5");
        chk("R5 regs", {8'h0, blink_mask, overlay_ctl, test_reg}, 32'h005B00E7);
        wr_ptr(8'h09, "R5"); wr_ctl(8'h12, "R5 ignored index");
        // control write did not move pointer or sequencer
        wr_col(8'h91, 8'h09, "R5"); wr_col(8'h92, 8'h09, "R5"); wr_col(8'h93, 8'h09, "R5");
        look(8'h09, "R5");
        chk("R5 entry9 after ctrl", {8'h0, pix_color}, 32'h919293);
        // R7: mask write and lookup at same edge: old mask used
        wr_ptr(8'h04, "R7");
        step(1'b1, 2'd2, 32'h03000000, 8'h05, "R7 same-edge mask");
        look(8'h05, "R7 new mask");
        wr_ctl(8'hFF, "R7");

        // R8: commit and lookup of same entry at same edge
        wr_ptr(8'h20, "R8");
        wr_col(8'hAA, 8'h20, "R8"); wr_col(8'hBB, 8'h20, "R8");
        wr_col(8'hCC, 8'h20, "R8 collide");
        chk("R8 old value on collision", {8'h0, pix_color}, 32'h0);
        look(8'h20, "R8");
        chk("R8 new value next", {8'h0, pix_color}, 32'hAABBCC);

        // R9: unused port code and idle
        step(1'b1, 2'd3, 32'h99000000, 8'h20, "R9");
        step(1'b0, 2'd1, 32'h99000000, 8'h20, "R9");
        wr_col(8'h44, 8'h21, "R9"); wr_col(8'h55, 8'h21, "R9"); wr_col(8'h66, 8'h21, "R9");
        look(8'h21, "R9");
        chk("R9 entry21", {8'h0, pix_color}, 32'h445566);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic we;
            logic [1:0] sel;
            we  = ($urandom % 4) != 0;
            sel = 2'($urandom % 4);
            step(we, sel, $urandom, 8'($urandom), "R7 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule